// File: doc/BRIEF.md
# Region-Based Memory Security Filter

This block sits beside a memory port and classifies every incoming transaction as allowed or denied. It compares the request address against a set of programmable address windows. Each window has a power-of-two size and is aligned to that size. It is split into eight equal slices that can be switched off one by one, and it carries four permission bits covering secure and non-secure reads and writes. Window 0 is a fixed background that spans the whole address space. Only its permission bits can be programmed. When several windows match, the one with the highest number decides.

Software programs the filter through a word-addressed 32-bit register port. Besides the window registers, this port gives access to an action selector for denied accesses and a strict or relaxed permission mode. It also holds a lockdown that freezes a range of windows, and a set of fail capture registers that feed an interrupt. The request side is a single address/valid port carrying a direction bit, a secure bit and an ID. The verdict comes back one cycle later.

Top module: `mem_sec_filter`

## Requirements
- R1: Word 0x00 is read-only and returns the address width minus one in bits [13:8] and the window count minus one in bits [3:0].
- R2: After reset, windows 1 and up read back as all-zero (disabled), window 0 permission is 0, action is 0, strict mode is off, lockdown is off, no interrupt is pending, and resp_valid is low.
- R3: Window 0 (words 0x10..0x12) always matches. Its base reads 0, and its attribute reads enable=1, size field = address width minus one, slice mask 0. Writes change only its permission bits [31:28].
- R4: Window n has base low at word 0x10+4n, base high at 0x11+4n and attributes at 0x12+4n. Attributes are: [0] enable, [6:1] size field S (window of 2^(S+1) bytes), [15:8] slice disables, [31:28] permission. Base bits below the window size are ignored. An enabled window with S below 14 never matches.
- R5: Slice k (bits S..S-2 of the address equal k) is excluded from its window's match when disable bit 8+k is set.
- R6: Among matching windows, the highest-numbered one decides. Window 0 decides only when no other window matches.
- R7: The permission bits are [28] secure read, [29] secure write, [30] non-secure read, [31] non-secure write. In strict mode (word 0x02 bit 0 = 1), an access is allowed only when the bit for its own state and direction is set.
- R8: With strict mode off, a secure access is also allowed when the non-secure bit for its direction is set. Non-secure accesses follow R7.
- R9: Action word 0x01 bits [1:0]: bit 0 raises resp_err on each denied response, and bit 1 drives irq while a failure is pending. resp_err never accompanies an allowed response.
- R10: The first denied access while nothing is pending captures its address (low word at 0x06, high word at 0x07), its direction and secure bits (word 0x08 bits [0] and [1]) and its ID (word 0x09), and marks a failure pending.
- R11: While a failure is pending, later denials leave the capture unchanged. Any write to word 0x05 clears the pending flag.
- R12: Word 0x03 holds lock enable [31] and the highest locked window [3:0]. Word 0x04 bit 0 activates the lock. Both read back as written. While active, base and attribute writes to windows 0 through the highest locked window are ignored.
- R13: resp_valid is high exactly in the cycle after a cycle with req_valid high, and resp_allow and resp_err are meaningful only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| req_valid | input | 1 | Transaction present |
| req_addr | input | ADDR_W | Transaction address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secure access |
| req_id | input | ID_W | Transaction ID |
| resp_valid | output | 1 | Verdict valid |
| resp_allow | output | 1 | Access allowed |
| resp_err | output | 1 | Error response requested for a denied access |
| irq | output | 1 | Failure interrupt |

## Verification
The assertions check, on every cycle, the one-cycle response pairing and that resp_err never coincides with an allowed verdict. They also check that the fail capture stays frozen while a failure is pending and no clear arrives, and that window 0's geometry and every locked window's registers never change. The address decoding itself can only be shown by the bench's scenarios. This covers size and alignment, slice exclusion, highest-number priority, the two permission modes, the action encodings and the register readback values, each checked against hand-derived expected verdicts.

// File: rtl/msf_pkg.sv
package msf_pkg;

    localparam int CFG_AW = 6;

    localparam logic [CFG_AW-1:0] W_BUILD   = 6'h00;
    localparam logic [CFG_AW-1:0] W_ACTION  = 6'h01;
    localparam logic [CFG_AW-1:0] W_STRICT  = 6'h02;
    localparam logic [CFG_AW-1:0] W_LOCKRNG = 6'h03;
    localparam logic [CFG_AW-1:0] W_LOCKSEL = 6'h04;
    localparam logic [CFG_AW-1:0] W_IRQCLR  = 6'h05;
    localparam logic [CFG_AW-1:0] W_FAILLO  = 6'h06;
    localparam logic [CFG_AW-1:0] W_FAILHI  = 6'h07;
    localparam logic [CFG_AW-1:0] W_FAILCTL = 6'h08;
    localparam logic [CFG_AW-1:0] W_FAILID  = 6'h09;
    localparam logic [CFG_AW-1:0] W_WIN0    = 6'h10;

    // smallest usable size field: 2^(14+1) = 32 KB
    localparam logic [5:0] MIN_SIZE_FIELD = 6'd14;

    typedef struct packed {
        logic [3:0] perm;    // [0] S rd, [1] S wr, [2] NS rd, [3] NS wr
        logic [7:0] sdis;    // slice disables
        logic [5:0] size;    // window = 2^(size+1) bytes
        logic       en;
    } win_attr_t;

    function automatic logic [31:0] attr_word(input win_attr_t a);
        return {a.perm, 12'd0, a.sdis, 1'b0, a.size, a.en};
    endfunction

endpackage

// File: rtl/msf_region_match.sv
module msf_region_match
    import msf_pkg::*;
(
    input  logic [63:0] base,
    input  logic        en,
    input  logic [5:0]  size,
    input  logic [7:0]  sdis,
    input  logic [63:0] addr,
    output logic        hit
);
    logic [63:0] low_mask;
    logic [2:0]  slice;
    logic        in_window;

    always_comb begin
        // 2 << 63 wraps to zero, so a size field of 63 gives an all-ones mask
        low_mask  = (64'd2 << size) - 64'd1;
        in_window = ((addr ^ base) & ~low_mask) == 64'd0;
        slice     = 3'((addr >> (size - 6'd2)) & 64'd7);
        hit       = en && (size >= MIN_SIZE_FIELD) && in_window && !sdis[slice];
    end

endmodule

// File: rtl/msf_perm_arbiter.sv
module msf_perm_arbiter #(
    parameter int NUM_REGIONS = 9
) (
    input  logic [NUM_REGIONS-1:1]      hits,
    input  logic [NUM_REGIONS-1:0][3:0] perms,
    input  logic                        strict,
    input  logic                        is_write,
    input  logic                        is_secure,
    output logic                        allow
);
    logic [3:0] p;
    logic       own_bit, ns_bit;

    always_comb begin
        p = perms[0];
        for (int n = 1; n < NUM_REGIONS; n++) begin
            if (hits[n]) p = perms[n];   // later index overrides: highest wins
        end
        ns_bit  = is_write ? p[3] : p[2];
        own_bit = is_secure ? (is_write ? p[1] : p[0]) : ns_bit;
        allow   = own_bit || (is_secure && !strict && ns_bit);
    end

endmodule

// File: rtl/mem_sec_filter.sv
module mem_sec_filter
    import msf_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int NUM_REGIONS = 9,
    parameter int ID_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [5:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_secure,
    input  logic [ID_W-1:0]   req_id,
    output logic              resp_valid,
    output logic              resp_allow,
    output logic              resp_err,
    output logic              irq
);
    localparam logic [5:0] TOP_SIZE = 6'(ADDR_W - 1);

    typedef struct packed {
        logic [NUM_REGIONS-1:0][31:0] base_lo;
        logic [NUM_REGIONS-1:0][31:0] base_hi;
        win_attr_t [NUM_REGIONS-1:0]  attr;
        logic [1:0]                   action;
        logic                         strict;
        logic                         lock_en;
        logic [3:0]                   lock_top;
        logic                         lock_sel;
        logic                         pend;
        logic [63:0]                  fail_addr;
        logic                         fail_wr;
        logic                         fail_sec;
        logic [ID_W-1:0]              fail_id;
        logic                         rsp_v;
        logic                         rsp_ok;
        logic                         rsp_err;
    } state_t;

    state_t s_d, s_q;

    logic [63:0]                  addr64;
    logic [NUM_REGIONS-1:1]       hits;
    logic [NUM_REGIONS-1:0][3:0]  perms;
    logic [NUM_REGIONS-1:0]       locked;
    logic                         allow;
    logic [5:0]                   win_off;
    logic [3:0]                   win_idx;
    logic [1:0]                   win_reg;
    logic                         win_space;
    logic                         clr_wr;

    assign addr64    = 64'(req_addr);
    assign win_off   = cfg_addr - W_WIN0;
    assign win_idx   = win_off[5:2];
    assign win_reg   = win_off[1:0];
    assign win_space = cfg_addr >= W_WIN0;
    assign clr_wr    = cfg_we && (cfg_addr == W_IRQCLR);

    generate
        for (genvar n = 1; n < NUM_REGIONS; n++) begin : g_match
            msf_region_match u_match (
                .base ({s_q.base_hi[n], s_q.base_lo[n]}),
                .en   (s_q.attr[n].en),
                .size (s_q.attr[n].size),
                .sdis (s_q.attr[n].sdis),
                .addr (addr64),
                .hit  (hits[n])
            );
        end
    endgenerate

    always_comb begin
        for (int n = 0; n < NUM_REGIONS; n++) begin
            perms[n]  = s_q.attr[n].perm;
            locked[n] = s_q.lock_sel && s_q.lock_en && (4'(n) <= s_q.lock_top);
        end
    end

    msf_perm_arbiter #(.NUM_REGIONS(NUM_REGIONS)) u_arb (
        .hits      (hits),
        .perms     (perms),
        .strict    (s_q.strict),
        .is_write  (req_write),
        .is_secure (req_secure),
        .allow     (allow)
    );

    // next state
    always_comb begin
        s_d         = s_q;
        s_d.rsp_v   = req_valid;
        s_d.rsp_ok  = req_valid && allow;
        s_d.rsp_err = req_valid && !allow && s_q.action[0];

        if (cfg_we) begin
            case (cfg_addr)
                W_ACTION:  s_d.action   = cfg_wdata[1:0];
                W_STRICT:  s_d.strict   = cfg_wdata[0];
                W_LOCKRNG: begin
                    s_d.lock_en  = cfg_wdata[31];
                    s_d.lock_top = cfg_wdata[3:0];
                end
                W_LOCKSEL: s_d.lock_sel = cfg_wdata[0];
                default: ;
            endcase
            for (int n = 0; n < NUM_REGIONS; n++) begin
                if (win_space && win_idx == 4'(n) && !locked[n]) begin
                    if (n == 0) begin
                        if (win_reg == 2'd2) s_d.attr[0].perm = cfg_wdata[31:28];
                    end else begin
                        case (win_reg)
                            2'd0: s_d.base_lo[n] = cfg_wdata;
                            2'd1: s_d.base_hi[n] = cfg_wdata;
                            2'd2: s_d.attr[n] = '{perm: cfg_wdata[31:28], sdis: cfg_wdata[15:8],
                                                  size: cfg_wdata[6:1],   en:   cfg_wdata[0]};
                            default: ;
                        endcase
                    end
                end
            end
        end

        if (clr_wr) s_d.pend = 1'b0;
        if (req_valid && !allow && !s_q.pend) begin
            s_d.pend      = 1'b1;
            s_d.fail_addr = addr64;
            s_d.fail_wr   = req_write;
            s_d.fail_sec  = req_secure;
            s_d.fail_id   = req_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.attr[0] <= '{perm: 4'd0, sdis: 8'd0, size: TOP_SIZE, en: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    // register readback
    always_comb begin
        cfg_rdata = 32'd0;
        case (cfg_addr)
            W_BUILD:   cfg_rdata = {18'd0, TOP_SIZE, 4'd0, 4'(NUM_REGIONS - 1)};
            W_ACTION:  cfg_rdata = {30'd0, s_q.action};
            W_STRICT:  cfg_rdata = {31'd0, s_q.strict};
            W_LOCKRNG: cfg_rdata = {s_q.lock_en, 27'd0, s_q.lock_top};
            W_LOCKSEL: cfg_rdata = {31'd0, s_q.lock_sel};
            W_FAILLO:  cfg_rdata = s_q.fail_addr[31:0];
            W_FAILHI:  cfg_rdata = s_q.fail_addr[63:32];
            W_FAILCTL: cfg_rdata = {30'd0, s_q.fail_sec, s_q.fail_wr};
            W_FAILID:  cfg_rdata = 32'(s_q.fail_id);
            default: ;
        endcase
        for (int n = 0; n < NUM_REGIONS; n++) begin
            if (win_space && win_idx == 4'(n)) begin
                case (win_reg)
                    2'd0:    cfg_rdata = s_q.base_lo[n];
                    2'd1:    cfg_rdata = s_q.base_hi[n];
                    2'd2:    cfg_rdata = attr_word(s_q.attr[n]);
                    default: cfg_rdata = 32'd0;
                endcase
            end
        end
    end

    assign resp_valid = s_q.rsp_v;
    assign resp_allow = s_q.rsp_ok;
    assign resp_err   = s_q.rsp_err;
    assign irq        = s_q.pend && s_q.action[1];

    // ---------------- assertions ----------------
    assert_resp_follows_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    assert_no_spurious_resp_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    assert_err_only_on_deny_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> (resp_valid && !resp_allow));

    assert_fail_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend && !clr_wr) |=> ($stable(s_q.fail_addr) && $stable(s_q.fail_id)
                                   && $stable(s_q.fail_wr) && $stable(s_q.fail_sec)));

    assert_win0_geometry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> ($stable(s_q.attr[0].size) && $stable(s_q.attr[0].sdis)
                    && s_q.attr[0].en && $stable(s_q.base_lo[0])));

    generate
        for (genvar n = 0; n < NUM_REGIONS; n++) begin : g_lock_chk
            assert_lock_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
                locked[n] |=> ($stable(s_q.attr[n]) && $stable(s_q.base_lo[n])
                               && $stable(s_q.base_hi[n])));
        end
    endgenerate

endmodule

// File: tb/tb_mem_sec_filter.sv
module tb_mem_sec_filter;

    localparam int AW = 32;
    localparam int IW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [5:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic          req_secure = 1'b0;
    logic [IW-1:0] req_id = '0;
    logic          resp_valid, resp_allow, resp_err, irq;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mem_sec_filter #(.ADDR_W(AW), .NUM_REGIONS(9), .ID_W(IW)) dut (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
        .req_valid, .req_addr, .req_write, .req_secure, .req_id,
        .resp_valid, .resp_allow, .resp_err, .irq
    );

    localparam logic [5:0] A_BUILD = 6'h00, A_ACT = 6'h01, A_STRICT = 6'h02,
                           A_LRNG = 6'h03, A_LSEL = 6'h04, A_CLR = 6'h05,
                           A_FLO = 6'h06, A_FHI = 6'h07, A_FCTL = 6'h08, A_FID = 6'h09;

    function automatic logic [5:0] wlo(input int n);  return 6'(16 + 4 * n);     endfunction
    function automatic logic [5:0] whi(input int n);  return 6'(16 + 4 * n + 1); endfunction
    function automatic logic [5:0] wat(input int n);  return 6'(16 + 4 * n + 2); endfunction
    function automatic logic [31:0] mk(input logic [3:0] perm, input logic [7:0] sd,
                                       input logic [5:0] sz, input logic en);
        return {perm, 12'd0, sd, 1'b0, sz, en};
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(tag, cfg_rdata, exp);
    endtask

    task automatic acc(input logic [31:0] a, input logic w, input logic s, input logic [7:0] id,
                       output logic ok, output logic er);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_secure = s; req_id = id;
        @(negedge clk);
        req_valid = 1'b0;
        ok = resp_allow; er = resp_err;
    endtask

    task automatic acc_chk(input string tag, input logic [31:0] a, input logic w,
                           input logic s, input logic exp_ok);
        logic ok, er;
        acc(a, w, s, 8'h00, ok, er);
        chk(tag, ok, exp_ok);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    task automatic t_reset();
        logic ok, er;
        chk("R2 resp_valid idle", resp_valid, 1'b0);
        chk("R2 irq idle", irq, 1'b0);
        rd_chk("R1 build word", A_BUILD, 32'h0000_1F08);
        rd_chk("R2 action", A_ACT, 32'h0);
        rd_chk("R2 win1 attr", wat(1), 32'h0);
        rd_chk("R3 win0 attr reset", wat(0), 32'h0000_003F);
        acc(32'h0000_1000, 1'b0, 1'b1, 8'h01, ok, er);
        chk("R13 resp_valid after req", resp_valid, 1'b1);
        chk("R2 win0 perm zero denies", ok, 1'b0);
        chk("R9 no err with action 0", er, 1'b0);
        @(negedge clk);
        chk("R13 resp_valid drops", resp_valid, 1'b0);
    endtask

    task automatic t_win0();
        wr(wlo(0), 32'hABCD_0000);
        rd_chk("R3 win0 base stays", wlo(0), 32'h0);
        wr(wat(0), 32'hF000_FFFF);
        rd_chk("R3 win0 only perm", wat(0), 32'hF000_003F);
        acc_chk("R3 background allow", 32'h1234_5678, 1'b1, 1'b0, 1'b1);
        wr(A_STRICT, 32'h1);
    endtask

    task automatic t_match();
        wr(wlo(1), 32'h0010_0000);
        wr(whi(1), 32'h0);
        wr(wat(1), mk(4'h0, 8'h00, 6'd19, 1'b1));
        acc_chk("R4 win1 start", 32'h0010_0000, 1'b0, 1'b1, 1'b0);
        acc_chk("R4 win1 end", 32'h001F_FFFC, 1'b0, 1'b1, 1'b0);
        acc_chk("R4 above win1", 32'h0020_0000, 1'b0, 1'b1, 1'b1);
        acc_chk("R4 below win1", 32'h000F_FFFC, 1'b0, 1'b1, 1'b1);
        wr(wlo(4), 32'h0030_8000);
        wr(wat(4), mk(4'h0, 8'h00, 6'd16, 1'b1));
        acc_chk("R4 unaligned base low bits ignored", 32'h0031_F000, 1'b0, 1'b1, 1'b0);
        acc_chk("R4 past unaligned window", 32'h0032_0000, 1'b0, 1'b1, 1'b1);
        wr(wat(4), 32'h0);
        wr(wlo(3), 32'h0040_0000);
        wr(wat(3), mk(4'h0, 8'h00, 6'd13, 1'b1));
        acc_chk("R4 size below 14 unused", 32'h0040_0000, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_slice();
        wr(wat(1), mk(4'h0, 8'h04, 6'd19, 1'b1));
        acc_chk("R5 disabled slice start", 32'h0014_0000, 1'b0, 1'b1, 1'b1);
        acc_chk("R5 disabled slice end", 32'h0015_FFFC, 1'b0, 1'b1, 1'b1);
        acc_chk("R5 slice below", 32'h0013_FFFC, 1'b0, 1'b1, 1'b0);
        acc_chk("R5 slice above", 32'h0016_0000, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_prio();
        wr(wlo(2), 32'h0010_0000);
        wr(wat(2), mk(4'hF, 8'h00, 6'd16, 1'b1));
        acc_chk("R6 win2 over win1", 32'h0010_0000, 1'b0, 1'b1, 1'b1);
        acc_chk("R6 win2 top", 32'h0011_FFFC, 1'b0, 1'b1, 1'b1);
        acc_chk("R6 only win1", 32'h0012_0000, 1'b0, 1'b1, 1'b0);
        wr(wlo(3), 32'h0010_0000);
        wr(wat(3), mk(4'h0, 8'h00, 6'd16, 1'b1));
        acc_chk("R6 win3 over win2", 32'h0010_0000, 1'b0, 1'b1, 1'b0);
        wr(wat(3), 32'h0);
    endtask

    task automatic t_perm();
        wr(wat(2), mk(4'h1, 8'h00, 6'd16, 1'b1));
        acc_chk("R7 S rd granted", 32'h0010_0000, 1'b0, 1'b1, 1'b1);
        acc_chk("R7 S wr denied", 32'h0010_0000, 1'b1, 1'b1, 1'b0);
        acc_chk("R7 NS rd denied", 32'h0010_0000, 1'b0, 1'b0, 1'b0);
        wr(wat(2), mk(4'h8, 8'h00, 6'd16, 1'b1));
        acc_chk("R7 NS wr granted", 32'h0010_0000, 1'b1, 1'b0, 1'b1);
        acc_chk("R7 strict S wr denied", 32'h0010_0000, 1'b1, 1'b1, 1'b0);
        acc_chk("R7 NS rd denied", 32'h0010_0000, 1'b0, 1'b0, 1'b0);
        wr(A_STRICT, 32'h0);
        acc_chk("R8 relaxed S wr via NS bit", 32'h0010_0000, 1'b1, 1'b1, 1'b1);
        acc_chk("R8 relaxed S rd denied", 32'h0010_0000, 1'b0, 1'b1, 1'b0);
        wr(wat(2), mk(4'h1, 8'h00, 6'd16, 1'b1));
        acc_chk("R8 NS rd still denied", 32'h0010_0000, 1'b0, 1'b0, 1'b0);
        acc_chk("R8 S rd granted", 32'h0010_0000, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_action();
        logic ok, er;
        wr(A_CLR, 32'h0);
        wr(A_ACT, 32'h1);
        acc(32'h0012_0000, 1'b0, 1'b0, 8'h02, ok, er);
        chk("R9 err on deny", er, 1'b1);
        chk("R9 no irq with bit1 clear", irq, 1'b0);
        wr(A_ACT, 32'h3);
        chk("R9 irq on pending", irq, 1'b1);
        acc(32'h0020_0000, 1'b0, 1'b0, 8'h02, ok, er);
        chk("R9 no err on allow", er, 1'b0);
        wr(A_CLR, 32'h0);
        chk("R11 clear drops irq", irq, 1'b0);
        wr(A_ACT, 32'h2);
        acc(32'h0012_0000, 1'b0, 1'b0, 8'h02, ok, er);
        chk("R9 irq only no err", er, 1'b0);
        chk("R9 irq raised", irq, 1'b1);
        wr(A_CLR, 32'h0);
    endtask

    task automatic t_fail();
        logic ok, er;
        acc(32'h0012_3454, 1'b1, 1'b0, 8'h5A, ok, er);
        chk("R10 deny", ok, 1'b0);
        rd_chk("R10 fail lo", A_FLO, 32'h0012_3454);
        rd_chk("R10 fail hi", A_FHI, 32'h0);
        rd_chk("R10 fail ctl", A_FCTL, 32'h1);
        rd_chk("R10 fail id", A_FID, 32'h5A);
        acc(32'h001A_0000, 1'b0, 1'b1, 8'h33, ok, er);
        rd_chk("R11 lo held", A_FLO, 32'h0012_3454);
        rd_chk("R11 id held", A_FID, 32'h5A);
        wr(A_CLR, 32'h0);
        chk("R11 irq cleared", irq, 1'b0);
        acc(32'h001A_0000, 1'b0, 1'b1, 8'h33, ok, er);
        rd_chk("R11 recapture lo", A_FLO, 32'h001A_0000);
        rd_chk("R10 recapture ctl", A_FCTL, 32'h2);
        rd_chk("R10 recapture id", A_FID, 32'h33);
        wr(A_CLR, 32'h0);
    endtask

    task automatic t_lock();
        wr(A_LRNG, 32'h8000_0002);
        rd_chk("R12 range readback", A_LRNG, 32'h8000_0002);
        wr(A_LSEL, 32'h1);
        rd_chk("R12 select readback", A_LSEL, 32'h1);
        wr(wat(1), 32'h0);
        rd_chk("R12 win1 attr frozen", wat(1), mk(4'h0, 8'h04, 6'd19, 1'b1));
        wr(wlo(2), 32'h0);
        rd_chk("R12 win2 base frozen", wlo(2), 32'h0010_0000);
        wr(wat(0), 32'h0);
        rd_chk("R12 win0 perm frozen", wat(0), 32'hF000_003F);
        wr(wat(3), mk(4'hF, 8'h00, 6'd13, 1'b1));
        rd_chk("R12 win3 writable", wat(3), 32'hF000_001B);
        acc_chk("R12 win1 still active", 32'h0012_0000, 1'b0, 1'b0, 1'b0);
        wr(A_LSEL, 32'h0);
        wr(wat(1), 32'h0);
        rd_chk("R12 unlock allows write", wat(1), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_win0();
        t_match();
        t_slice();
        t_prio();
        t_perm();
        t_action();
        t_fail();
        t_lock();
        repeat (2) @(negedge clk);
        finish_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_up();
    end

endmodule